// File: doc/BRIEF.md
# Packed Integer Lane ALU

This block is a 64-bit SIMD integer unit. A single 64-bit word is treated as a row of lanes, 8, 16, 32 or 64 bits wide. Each operation code picks both an operation and a lane width. Operations fall into five groups:

- wraparound add and subtract
- signed-saturating and unsigned-saturating add and subtract
- equality and signed greater-than compares that produce lane masks
- whole-word bitwise logic
- logical and arithmetic shifts

Two operands enter the block: the destination word `dst_opd` and the source word `src_opd`. Every operation has the form "destination op source". The result is captured in an output register when `in_valid` is high, so it appears on the cycle after the strobe. There is no backpressure. A strobe with an undefined operation code returns zero and raises `illegal_op` for that one result cycle. Full-width 64-bit add and subtract are an option chosen by the parameter `QWORD_ARITH`.

Top module: `lane_alu`

## Requirements
- R1: On each rising clock edge where `in_valid` is high, the block registers the result of `op_code` applied to `dst_opd` and `src_opd`. Both `result` and `out_valid` show this result on the next cycle, and `out_valid` is high only in cycles that follow a strobe, so back-to-back strobes give back-to-back results.
- R2: After reset, `out_valid`, `illegal_op` and `result` are all zero. In a cycle that follows no strobe, `result` keeps its previous value.
- R3: Codes 1, 2 and 3 add, and codes 5, 6 and 7 subtract (dst minus src), on 8-, 16- and 32-bit lanes in that order. Each lane wraps modulo 2^W and no carry crosses a lane boundary.
- R4: When `QWORD_ARITH` is 1 (the default), code 4 is a 64-bit add and code 8 is a 64-bit subtract. When it is 0, both codes are treated as illegal.
- R5: Signed-saturating add uses code 9 (8-bit lanes) and code 10 (16-bit lanes). Signed-saturating subtract uses code 13 (8-bit) and code 14 (16-bit). A lane whose exact signed result overflows is clamped to the lane's most positive or most negative value.
- R6: Unsigned-saturating add uses code 11 (8-bit lanes) and code 12 (16-bit lanes). Unsigned-saturating subtract uses code 15 (8-bit) and code 16 (16-bit). An add that overflows clamps the lane to all ones, and a subtract that would go negative clamps it to zero.
- R7: Codes 17, 18 and 19 test equality on 8-, 16- and 32-bit lanes. Codes 20, 21 and 22 test signed dst > src on the same widths. A lane is set to all ones when the test is true and to zero when it is false.
- R8: Code 23 gives dst AND src, code 24 gives (NOT dst) AND src, code 25 gives dst OR src and code 26 gives dst XOR src, each across the whole 64-bit word.
- R9: Codes 27, 28 and 29 shift dst left logically, and codes 30, 31 and 32 shift it right logically, on 16-, 32- and 64-bit lanes in that order. The count is the whole 64-bit `src_opd` taken as unsigned. A count at or above the lane width gives zero.
- R10: Codes 33 and 34 shift dst right arithmetically on 16- and 32-bit lanes. A count at or above the lane width fills each lane with its sign bit.
- R11: Every other code (0 and 35 to 63) gives a zero result with `illegal_op` high, for exactly the cycle in which `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe that captures a new operation |
| op_code | input | 6 | Operation and lane width code |
| src_opd | input | 64 | Source operand, and the shift count |
| dst_opd | input | 64 | Destination operand |
| out_valid | output | 1 | High for one cycle when a result is presented |
| result | output | 64 | Registered result |
| illegal_op | output | 1 | The presented result came from an undefined code |

## Verification
The clocked properties assume three things about the inputs: `in_valid` is low while reset is held, `in_valid` is never unknown at a clock edge, and `in_valid`, `op_code` and both operands stay steady around the rising edge. The bench keeps to all three. It holds reset for several cycles with the strobe low, and it changes inputs only on falling edges. It sweeps all 64 codes, so every illegal code is covered, against operand patterns chosen to hit lane signs, carries, overflow limits and shift counts on either side of each lane width. Several random pairs are added for each code.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

   localparam int OPC_W = 6;

   typedef enum logic [OPC_W-1:0] {
      OP_ADD8   = 6'd1,  OP_ADD16  = 6'd2,  OP_ADD32  = 6'd3,  OP_ADD64  = 6'd4,
      OP_SUB8   = 6'd5,  OP_SUB16  = 6'd6,  OP_SUB32  = 6'd7,  OP_SUB64  = 6'd8,
      OP_SADD8  = 6'd9,  OP_SADD16 = 6'd10, OP_UADD8  = 6'd11, OP_UADD16 = 6'd12,
      OP_SSUB8  = 6'd13, OP_SSUB16 = 6'd14, OP_USUB8  = 6'd15, OP_USUB16 = 6'd16,
      OP_EQ8    = 6'd17, OP_EQ16   = 6'd18, OP_EQ32   = 6'd19,
      OP_GT8    = 6'd20, OP_GT16   = 6'd21, OP_GT32   = 6'd22,
      OP_AND    = 6'd23, OP_ANDN   = 6'd24, OP_OR     = 6'd25, OP_XOR    = 6'd26,
      OP_SLL16  = 6'd27, OP_SLL32  = 6'd28, OP_SLL64  = 6'd29,
      OP_SRL16  = 6'd30, OP_SRL32  = 6'd31, OP_SRL64  = 6'd32,
      OP_SRA16  = 6'd33, OP_SRA32  = 6'd34
   } alu_op_e;

   typedef enum logic [1:0] {
      SAT_WRAP     = 2'd0,
      SAT_SIGNED   = 2'd1,
      SAT_UNSIGNED = 2'd2
   } sat_mode_e;

endpackage

// File: rtl/lane_addsub.sv
module lane_addsub
   import lane_alu_pkg::*;
#(
   parameter int WORD_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [WORD_W-1:0] opd_a,
   input  logic [WORD_W-1:0] opd_b,
   input  logic              do_sub,
   input  sat_mode_e         mode,
   output logic [WORD_W-1:0] sum_y
);

   localparam int NUM_LANES = WORD_W / LANE_W;
   localparam int MSB       = LANE_W - 1;

   generate
      if ((WORD_W % LANE_W) != 0 || LANE_W < 2) begin : g_bad_cfg
         $error("lane_addsub: lane width must divide word width");
      end

      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         logic [LANE_W-1:0] x_l, z_l, raw_l, y_l;
         logic [LANE_W:0]   ext_l;
         logic              ovf_l;

         assign x_l   = opd_a[i*LANE_W +: LANE_W];
         assign z_l   = opd_b[i*LANE_W +: LANE_W];
         assign ext_l = do_sub ? ({1'b0, x_l} - {1'b0, z_l})
                               : ({1'b0, x_l} + {1'b0, z_l});
         assign raw_l = ext_l[LANE_W-1:0];
         assign ovf_l = do_sub ? ((x_l[MSB] != z_l[MSB]) && (raw_l[MSB] != x_l[MSB]))
                               : ((x_l[MSB] == z_l[MSB]) && (raw_l[MSB] != x_l[MSB]));

         always_comb begin
            case (mode)
               SAT_SIGNED:
                  y_l = !ovf_l ? raw_l
                      : (x_l[MSB] ? {1'b1, {(LANE_W-1){1'b0}}} : {1'b0, {(LANE_W-1){1'b1}}});
               SAT_UNSIGNED:
                  y_l = !ext_l[LANE_W] ? raw_l : (do_sub ? '0 : '1);
               default:
                  y_l = raw_l;
            endcase
         end

         assign sum_y[i*LANE_W +: LANE_W] = y_l;
      end
   endgenerate

endmodule

// File: rtl/lane_compare.sv
module lane_compare #(
   parameter int WORD_W = 64,
   parameter int LANE_W = 8
) (
   input  logic [WORD_W-1:0] opd_a,
   input  logic [WORD_W-1:0] opd_b,
   output logic [WORD_W-1:0] eq_mask,
   output logic [WORD_W-1:0] gt_mask
);

   localparam int NUM_LANES = WORD_W / LANE_W;

   generate
      if ((WORD_W % LANE_W) != 0 || LANE_W < 2) begin : g_bad_cfg
         $error("lane_compare: lane width must divide word width");
      end

      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         logic signed [LANE_W-1:0] xs_l, zs_l;
         assign xs_l = opd_a[i*LANE_W +: LANE_W];
         assign zs_l = opd_b[i*LANE_W +: LANE_W];
         assign eq_mask[i*LANE_W +: LANE_W] = {LANE_W{xs_l == zs_l}};
         assign gt_mask[i*LANE_W +: LANE_W] = {LANE_W{xs_l > zs_l}};
      end
   endgenerate

endmodule

// File: rtl/lane_shifter.sv
module lane_shifter #(
   parameter int WORD_W = 64,
   parameter int LANE_W = 16
) (
   input  logic [WORD_W-1:0] data,
   input  logic [WORD_W-1:0] count,
   output logic [WORD_W-1:0] sll_y,
   output logic [WORD_W-1:0] srl_y,
   output logic [WORD_W-1:0] sra_y
);

   localparam int NUM_LANES = WORD_W / LANE_W;
   localparam int SH_W      = $clog2(LANE_W);

   logic            too_far;
   logic [SH_W-1:0] amt;

   // the whole count word is significant: any bit at or above the lane width index ends the shift
   assign too_far = |count[WORD_W-1:SH_W];
   assign amt     = count[SH_W-1:0];

   generate
      if ((WORD_W % LANE_W) != 0 || (1 << SH_W) != LANE_W) begin : g_bad_cfg
         $error("lane_shifter: lane width must be a power of two dividing the word");
      end

      for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
         logic        [LANE_W-1:0] x_l;
         logic signed [LANE_W-1:0] xs_l;
         assign x_l  = data[i*LANE_W +: LANE_W];
         assign xs_l = x_l;
         assign sll_y[i*LANE_W +: LANE_W] = too_far ? '0 : (x_l << amt);
         assign srl_y[i*LANE_W +: LANE_W] = too_far ? '0 : (x_l >> amt);
         assign sra_y[i*LANE_W +: LANE_W] = too_far ? {LANE_W{x_l[LANE_W-1]}}
                                                    : $unsigned(xs_l >>> amt);
      end
   endgenerate

endmodule

// File: rtl/lane_alu.sv
module lane_alu
   import lane_alu_pkg::*;
#(
   parameter int WORD_W      = 64,
   parameter bit QWORD_ARITH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [5:0]        op_code,
   input  logic [WORD_W-1:0] src_opd,
   input  logic [WORD_W-1:0] dst_opd,
   output logic              out_valid,
   output logic [WORD_W-1:0] result,
   output logic              illegal_op
);

   localparam int NUM_GRP = 3;

   generate
      if (WORD_W != 64) begin : g_bad_word
         $error("lane_alu: the lane code map assumes a 64-bit word");
      end
   endgenerate

   alu_op_e   opc;
   logic      do_sub;
   sat_mode_e mode;

   assign opc = alu_op_e'(op_code);

   always_comb begin
      do_sub = 1'b0;
      mode   = SAT_WRAP;
      case (opc)
         OP_SUB8, OP_SUB16, OP_SUB32, OP_SUB64:  do_sub = 1'b1;
         OP_SADD8, OP_SADD16:                    mode   = SAT_SIGNED;
         OP_UADD8, OP_UADD16:                    mode   = SAT_UNSIGNED;
         OP_SSUB8, OP_SSUB16: begin do_sub = 1'b1; mode = SAT_SIGNED;   end
         OP_USUB8, OP_USUB16: begin do_sub = 1'b1; mode = SAT_UNSIGNED; end
         default: ;
      endcase
   end

   logic [WORD_W-1:0] arith_y [NUM_GRP];
   logic [WORD_W-1:0] eq_m    [NUM_GRP];
   logic [WORD_W-1:0] gt_m    [NUM_GRP];
   logic [WORD_W-1:0] sll_m   [NUM_GRP];
   logic [WORD_W-1:0] srl_m   [NUM_GRP];
   logic [WORD_W-1:0] sra_m   [NUM_GRP];
   logic [WORD_W-1:0] quad_y;

   generate
      for (genvar k = 0; k < NUM_GRP; k++) begin : g_grp
         lane_addsub #(.WORD_W(WORD_W), .LANE_W(8 << k)) u_addsub (
            .opd_a (dst_opd), .opd_b (src_opd), .do_sub (do_sub), .mode (mode),
            .sum_y (arith_y[k])
         );
         lane_compare #(.WORD_W(WORD_W), .LANE_W(8 << k)) u_cmp (
            .opd_a (dst_opd), .opd_b (src_opd),
            .eq_mask (eq_m[k]), .gt_mask (gt_m[k])
         );
         lane_shifter #(.WORD_W(WORD_W), .LANE_W(16 << k)) u_shift (
            .data (dst_opd), .count (src_opd),
            .sll_y (sll_m[k]), .srl_y (srl_m[k]), .sra_y (sra_m[k])
         );
      end

      if (QWORD_ARITH) begin : g_quad
         lane_addsub #(.WORD_W(WORD_W), .LANE_W(WORD_W)) u_addsub64 (
            .opd_a (dst_opd), .opd_b (src_opd), .do_sub (do_sub), .mode (SAT_WRAP),
            .sum_y (quad_y)
         );
      end else begin : g_no_quad
         assign quad_y = '0;
      end
   endgenerate

   logic [WORD_W-1:0] nxt_res;
   logic              nxt_ill;

   always_comb begin
      nxt_res = '0;
      nxt_ill = 1'b0;
      case (opc)
         OP_ADD8,  OP_SUB8,  OP_SADD8,  OP_SSUB8,  OP_UADD8,  OP_USUB8:  nxt_res = arith_y[0];
         OP_ADD16, OP_SUB16, OP_SADD16, OP_SSUB16, OP_UADD16, OP_USUB16: nxt_res = arith_y[1];
         OP_ADD32, OP_SUB32: nxt_res = arith_y[2];
         OP_ADD64, OP_SUB64: begin
            if (QWORD_ARITH) nxt_res = quad_y;
            else             nxt_ill = 1'b1;
         end
         OP_EQ8:   nxt_res = eq_m[0];
         OP_EQ16:  nxt_res = eq_m[1];
         OP_EQ32:  nxt_res = eq_m[2];
         OP_GT8:   nxt_res = gt_m[0];
         OP_GT16:  nxt_res = gt_m[1];
         OP_GT32:  nxt_res = gt_m[2];
         OP_AND:   nxt_res = dst_opd & src_opd;
         OP_ANDN:  nxt_res = ~dst_opd & src_opd;
         OP_OR:    nxt_res = dst_opd | src_opd;
         OP_XOR:   nxt_res = dst_opd ^ src_opd;
         OP_SLL16: nxt_res = sll_m[0];
         OP_SLL32: nxt_res = sll_m[1];
         OP_SLL64: nxt_res = sll_m[2];
         OP_SRL16: nxt_res = srl_m[0];
         OP_SRL32: nxt_res = srl_m[1];
         OP_SRL64: nxt_res = srl_m[2];
         OP_SRA16: nxt_res = sra_m[0];
         OP_SRA32: nxt_res = sra_m[1];
         default:  nxt_ill = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         illegal_op <= 1'b0;
         result     <= '0;
      end else begin
         out_valid  <= in_valid;
         illegal_op <= in_valid & nxt_ill;
         if (in_valid) result <= nxt_res;
      end
   end

   AST_VALID_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(in_valid)); // R1
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !$past(in_valid) |-> $stable(result)); // R2
   AST_ILLEGAL_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n) illegal_op |-> (out_valid && result == '0)); // R11
   AST_CMP_MASKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) (eq_m[0] & gt_m[0]) == '0); // R7

endmodule

// File: tb/test_lane_alu.sv
`timescale 1ns/1ps
module test_lane_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [5:0]  op_code = '0;
   logic [63:0] src_opd = '0;
   logic [63:0] dst_opd = '0;
   logic        out_valid;
   logic [63:0] result;
   logic        illegal_op;

   int n_run  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   lane_alu i_lane_alu (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op_code (op_code),
      .src_opd (src_opd), .dst_opd (dst_opd),
      .out_valid (out_valid), .result (result), .illegal_op (illegal_op)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // per-lane arithmetic and compare model
   // kinds: 0 add, 1 sub, 2 sadd, 3 ssub, 4 uadd, 5 usub, 6 eq, 7 gt
   function automatic logic [63:0] lane_ref(int kind, int w, logic [63:0] d, logic [63:0] s);
      logic [63:0] r;
      longint m, half, ua, ub, sa, sb, v;
      r = '0;
      m = (longint'(1) << w) - 1;
      half = longint'(1) << (w - 1);
      for (int l = 0; l < 64 / w; l++) begin
         ua = longint'(d >> (l * w)) & m;
         ub = longint'(s >> (l * w)) & m;
         sa = (ua >= half) ? ua - (m + 1) : ua;
         sb = (ub >= half) ? ub - (m + 1) : ub;
         case (kind)
            0: v = ua + ub;
            1: v = ua - ub;
            2: begin v = sa + sb; if (v > half - 1) v = half - 1; if (v < -half) v = -half; end
            3: begin v = sa - sb; if (v > half - 1) v = half - 1; if (v < -half) v = -half; end
            4: v = (ua + ub > m) ? m : ua + ub;
            5: v = (ua < ub) ? 0 : ua - ub;
            6: v = (ua == ub) ? m : 0;
            default: v = (sa > sb) ? m : 0;
         endcase
         r = r | (64'(v & m) << (l * w));
      end
      return r;
   endfunction

   // bit-level shift model: kinds 0 left logical, 1 right logical, 2 right arithmetic
   function automatic logic [63:0] shift_ref(int kind, int w, logic [63:0] d, logic [63:0] s);
      logic [63:0] r;
      int c, src;
      bit big;
      r = '0;
      big = (s >= 64'(w));
      c = big ? w : int'(s);
      for (int l = 0; l < 64 / w; l++) begin
         for (int b = 0; b < w; b++) begin
            case (kind)
               0: begin src = b - c; r[l*w+b] = (src >= 0) ? d[l*w+src] : 1'b0; end
               1: begin src = b + c; r[l*w+b] = (src < w) ? d[l*w+src] : 1'b0; end
               default: begin src = b + c; r[l*w+b] = (src < w) ? d[l*w+src] : d[l*w+w-1]; end
            endcase
         end
      end
      return r;
   endfunction

   function automatic logic [63:0] model(int op, logic [63:0] d, logic [63:0] s, output bit ill);
      ill = 1'b0;
      case (op)
         1: return lane_ref(0, 8, d, s);   2: return lane_ref(0, 16, d, s);
         3: return lane_ref(0, 32, d, s);  4: return d + s;
         5: return lane_ref(1, 8, d, s);   6: return lane_ref(1, 16, d, s);
         7: return lane_ref(1, 32, d, s);  8: return d - s;
         9: return lane_ref(2, 8, d, s);   10: return lane_ref(2, 16, d, s);
         11: return lane_ref(4, 8, d, s);  12: return lane_ref(4, 16, d, s);
         13: return lane_ref(3, 8, d, s);  14: return lane_ref(3, 16, d, s);
         15: return lane_ref(5, 8, d, s);  16: return lane_ref(5, 16, d, s);
         17: return lane_ref(6, 8, d, s);  18: return lane_ref(6, 16, d, s);
         19: return lane_ref(6, 32, d, s); 20: return lane_ref(7, 8, d, s);
         21: return lane_ref(7, 16, d, s); 22: return lane_ref(7, 32, d, s);
         23: return d & s;  24: return ~d & s;  25: return d | s;  26: return d ^ s;
         27: return shift_ref(0, 16, d, s); 28: return shift_ref(0, 32, d, s);
         29: return shift_ref(0, 64, d, s); 30: return shift_ref(1, 16, d, s);
         31: return shift_ref(1, 32, d, s); 32: return shift_ref(1, 64, d, s);
         33: return shift_ref(2, 16, d, s); 34: return shift_ref(2, 32, d, s);
         default: begin ill = 1'b1; return '0; end
      endcase
   endfunction

   function automatic string req_of(int op);
      if (op == 4 || op == 8)  return "R4";
      if (op >= 1 && op <= 7)  return "R3";
      if (op == 9 || op == 10 || op == 13 || op == 14) return "R5";
      if (op >= 11 && op <= 16) return "R6";
      if (op >= 17 && op <= 22) return "R7";
      if (op >= 23 && op <= 26) return "R8";
      if (op >= 27 && op <= 32) return "R9";
      if (op == 33 || op == 34) return "R10";
      return "R11";
   endfunction

   function automatic logic [63:0] pat_d(int p);
      case (p)
         0: return 64'h0;
         1: return 64'hFFFF_FFFF_FFFF_FFFF;
         2: return 64'h7F7F_7FFF_7FFF_FFFF;
         3: return 64'h8080_8000_8000_0000;
         4: return 64'h0123_4567_89AB_CDEF;
         5: return 64'h7FFF_8000_7F80_0180;
         6: return 64'hFF00_00FF_F0F0_0F0F;
         7: return 64'h8000_0000_0000_0001;
         default: return {$urandom, $urandom};
      endcase
   endfunction

   function automatic logic [63:0] pat_s(int p);
      case (p)
         0: return 64'h0;
         1: return 64'h0101_0101_0001_0001;
         2: return 64'h0101_0001_0001_0001;
         3: return 64'h0101_0001_0001_0001;
         4: return 64'h0123_4567_89AB_CDEF;
         5: return 64'h8001_7FFF_8080_0280;
         6: return 64'hFFFF_FFFF_FFFF_FFFF;
         7: return 64'h0000_0000_0000_0002;
         default: return {$urandom, $urandom};
      endcase
   endfunction

   function automatic logic [63:0] pat_cnt(int p);
      case (p)
         0: return 64'd0;   1: return 64'd1;   2: return 64'd7;   3: return 64'd15;
         4: return 64'd16;  5: return 64'd17;  6: return 64'd31;  7: return 64'd32;
         8: return 64'd33;  9: return 64'd63;  10: return 64'd64; 11: return 64'd65;
         12: return 64'h1_0000_0003;
         13: return 64'hFFFF_FFFF_FFFF_FFFF;
         default: return 64'($urandom_range(0, 70));
      endcase
   endfunction

   task automatic apply_and_check(int op, logic [63:0] d, logic [63:0] s);
      logic [63:0] exp;
      bit ill;
      string rq;
      exp = model(op, d, s, ill);
      rq = req_of(op);
      @(negedge clk);
      op_code  = 6'(op);
      dst_opd  = d;
      src_opd  = s;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk({rq, " result"}, result, exp);
      chk("R1 out_valid after strobe", 64'(out_valid), 64'd1);
      chk("R11 illegal flag", 64'(illegal_op), 64'(ill));
      // idle cycle: result held, flags drop
      op_code = 6'(op + 1);
      dst_opd = ~d;
      @(negedge clk);
      chk("R2 result held", result, exp);
      chk("R1 out_valid single pulse", 64'(out_valid), 64'd0);
      chk("R11 illegal flag one cycle", 64'(illegal_op), 64'd0);
   endtask

   initial begin
      #500_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R2 reset result", result, 64'd0);
      chk("R2 reset out_valid", 64'(out_valid), 64'd0);
      chk("R2 reset illegal_op", 64'(illegal_op), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int op = 0; op < 64; op++) begin
         for (int p = 0; p < 16; p++) begin
            if (op >= 27 && op <= 34) apply_and_check(op, pat_d(p), pat_cnt(p));
            else                      apply_and_check(op, pat_d(p), pat_s(p));
         end
      end

      // back-to-back strobes (R1)
      begin
         logic [63:0] e1, e2;
         bit i1, i2;
         e1 = model(1, 64'h10FF, 64'h0101, i1);
         e2 = model(40, 64'h1234, 64'h1, i2);
         @(negedge clk);
         op_code = 6'd1; dst_opd = 64'h10FF; src_opd = 64'h0101; in_valid = 1'b1;
         @(negedge clk);
         chk("R1 back-to-back first", result, e1);
         chk("R1 back-to-back first illegal", 64'(illegal_op), 64'(i1));
         op_code = 6'd40; dst_opd = 64'h1234; src_opd = 64'h1;
         @(negedge clk);
         in_valid = 1'b0;
         chk("R1 back-to-back second", result, e2);
         chk("R1 back-to-back valid", 64'(out_valid), 64'd1);
         chk("R11 back-to-back illegal", 64'(illegal_op), 64'(i2));
         @(negedge clk);
         chk("R1 valid drops", 64'(out_valid), 64'd0);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule